// File: doc/BRIEF.md
# Debug Memory Breakpoint Unit

This block watches the processor bus through two independent address-watch channels. Each channel holds a base address, a compare mask, a window-sense select and a small control field. The control field switches the channel on and chooses which access kinds it reacts to: data reads, data writes or instruction fetches. A channel fires when a qualifying access lands inside its masked window. With the window sense inverted, it fires when the access lands outside that window instead.

Channel A always raises a breakpoint request. Channel B does one of two things, chosen by a freeze-select control. It raises the request, or it silently freezes a small history of recently fetched program-counter values while the processor keeps running. The frozen history stays frozen until software clears a sticky status bit. A trace-enable control gates whether fetches are recorded at all.

Software sets the block up through a simple register write port. A debugger reads the history through an index port.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: A channel's address test is true when ((bus_addr XOR base) AND mask) == 0 over 32 bits. A mask bit of 1 means that address bit is compared, and a mask bit of 0 means it is ignored.
- R2: Each channel has a window-sense bit. At 0 the channel fires on accesses where the address test is true. At 1 it fires on accesses where the address test is false.
- R3: Each channel has a 5-bit control field: bit0 switches the channel on, bit1 selects reads, bit2 selects writes, bit3 selects fetches, and bit4 is ignored. A channel fires only for a valid access whose kind is selected while bit0 is 1.
- R4: `bkpt_req` is a one-cycle pulse in the cycle after the bus access that fired. It is raised by a channel A hit, or by a channel B hit while freeze-select is 0.
- R5: While freeze-select is 1, a channel B hit raises no request and sets `fifo_frozen` in the following cycle. A channel A hit still raises the request.
- R6: While `fifo_frozen` is 1, the history accepts no new entries. Writing a 1 in bit0 to offset 5 clears `fifo_frozen`, and writing 0 there leaves it set.
- R7: The history holds 8 entries. It records the address of every valid fetch while trace is on and the history is not frozen, overwriting the oldest entry when full. `hist_idx` 0 reads the newest entry and 7 reads the oldest. The fetch that triggers a freeze is itself recorded.
- R8: The trace-enable bit gates recording. With trace off, no fetch enters the history, but breakpoint matching continues.
- R9: Synchronous reset clears both control fields, trace-enable, freeze-select, all bases and masks, `fifo_frozen`, `bkpt_req` and every history entry.
- R10: The register offsets are 0 for the A base, 1 for the A mask, 2 for the B base, 3 for the B mask, 4 for control and 5 for status. The control word holds the A field in [4:0], the A window sense in [5], the B field in [10:6], the B window sense in [11], freeze-select in [12] and trace-enable in [13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 32 | Register write data |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | 32 | Bus access address |
| bus_rd | input | 1 | Access is a data read |
| bus_wr | input | 1 | Access is a data write |
| bus_fetch | input | 1 | Access is an instruction fetch |
| hist_idx | input | 3 | History read index, 0 = newest |
| bkpt_req | output | 1 | Breakpoint request pulse |
| fifo_frozen | output | 1 | History frozen status |
| hist_pc | output | 32 | History entry selected by hist_idx |

## Verification
The hardest state to reach from the ports is a frozen history that is then proven unchanged. To get there, the stimulus must enable freeze-select, make an out-of-window fetch hit channel B, and keep fetching afterwards. Only then does reading the newest slot show that the triggering fetch was kept and later fetches were dropped. A channel A read during the freeze confirms that requests still flow. A zero write to the status offset shows the freeze holds before the clearing write restores recording.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

    localparam int ADDR_W     = 32;
    localparam int NUM_CH     = 2;
    localparam int CTL_W      = 5;
    localparam int CTL_STRIDE = 6;

    localparam int OFF_CTRL   = 4;
    localparam int OFF_STAT   = 5;
    localparam int BIT_FREEZE = 12;
    localparam int BIT_TRACE  = 13;

    typedef struct packed {
        logic fetch;
        logic wr;
        logic rd;
        logic en;
    } chan_ctl_t;

    typedef struct packed {
        logic              outside;
        chan_ctl_t         ctl;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } chan_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              rd;
        logic              wr;
        logic              fetch;
        logic [ADDR_W-1:0] addr;
    } bus_acc_t;

    function automatic logic addr_in_window(input logic [ADDR_W-1:0] addr,
                                            input logic [ADDR_W-1:0] base,
                                            input logic [ADDR_W-1:0] mask);
        return ((addr ^ base) & mask) == '0;
    endfunction

    function automatic logic kind_selected(input chan_ctl_t ctl, input bus_acc_t acc);
        return (acc.rd & ctl.rd) | (acc.wr & ctl.wr) | (acc.fetch & ctl.fetch);
    endfunction

endpackage

// File: rtl/bkpt_channel.sv
module bkpt_channel
    import dbg_bkpt_pkg::*;
(
    input  chan_cfg_t cfg,
    input  bus_acc_t  acc,
    output logic      hit
);
    logic in_win;

    always_comb begin
        in_win = addr_in_window(acc.addr, cfg.base, cfg.mask);
        hit    = acc.valid & cfg.ctl.en & kind_selected(cfg.ctl, acc)
                 & (in_win ^ cfg.outside);
    end
endmodule

// File: rtl/pc_history.sv
module pc_history #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_pc,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_pc
);
    logic [W-1:0]  slots [DEPTH];
    logic [IW-1:0] wp;
    logic [IW-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (push) begin
            slots[wp] <= push_pc;
            wp        <= wp + IW'(1);
        end
    end

    always_comb begin
        sel   = wp - rd_idx - IW'(1);
        rd_pc = slots[sel];
    end
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter int HIST_DEPTH = 8,
    parameter int REG_AW     = 3,
    localparam int HIST_IW   = $clog2(HIST_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  wr_addr,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               bus_fetch,
    input  logic [HIST_IW-1:0] hist_idx,
    output logic               bkpt_req,
    output logic               fifo_frozen,
    output logic [ADDR_W-1:0]  hist_pc
);
    chan_cfg_t         cfg_q [NUM_CH];
    logic              freeze_q;
    logic              trace_on;
    logic              frozen_q;
    logic              req_q;
    logic [NUM_CH-1:0] hit;
    bus_acc_t          acc;
    logic              freeze_evt;
    logic              clear_wr;
    logic              push;

    always_comb begin
        acc.valid = bus_valid;
        acc.rd    = bus_rd;
        acc.wr    = bus_wr;
        acc.fetch = bus_fetch;
        acc.addr  = bus_addr;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bkpt_channel u_ch (
            .cfg (cfg_q[g]),
            .acc (acc),
            .hit (hit[g])
        );
    end

    always_comb begin
        freeze_evt = hit[1] & freeze_q;
        clear_wr   = wr_en && (wr_addr == REG_AW'(OFF_STAT)) && wr_data[0];
        push       = bus_valid & bus_fetch & trace_on & ~frozen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= '0;
            freeze_q <= 1'b0;
            trace_on <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == REG_AW'(2 * i))     cfg_q[i].base <= wr_data;
                if (wr_addr == REG_AW'(2 * i + 1)) cfg_q[i].mask <= wr_data;
                if (wr_addr == REG_AW'(OFF_CTRL)) begin
                    cfg_q[i].ctl     <= chan_ctl_t'(wr_data[i*CTL_STRIDE +: CTL_W-1]);
                    cfg_q[i].outside <= wr_data[i*CTL_STRIDE + CTL_W];
                end
            end
            if (wr_addr == REG_AW'(OFF_CTRL)) begin
                freeze_q <= wr_data[BIT_FREEZE];
                trace_on <= wr_data[BIT_TRACE];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            frozen_q <= 1'b0;
        end else begin
            req_q <= hit[0] | (hit[1] & ~freeze_q);
            if (freeze_evt)    frozen_q <= 1'b1;
            else if (clear_wr) frozen_q <= 1'b0;
        end
    end

    pc_history #(.DEPTH(HIST_DEPTH), .W(ADDR_W)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .push_pc (bus_addr),
        .rd_idx  (hist_idx),
        .rd_pc   (hist_pc)
    );

    assign bkpt_req    = req_q;
    assign fifo_frozen = frozen_q;
endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk #(
    parameter int IW = 3,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [31:0]   wr_data,
    input logic          bus_valid,
    input logic [IW-1:0] hist_idx,
    input logic          bkpt_req,
    input logic          fifo_frozen,
    input logic [31:0]   hist_pc,
    input logic          trace_on
);
    // R4: a request only follows a valid bus access
    p_req_after_access_r4: assert property (@(posedge clk) disable iff (rst)
        bkpt_req |-> $past(bus_valid));

    // R5: the freeze only starts after a valid bus access
    p_freeze_after_access_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_frozen) |-> $past(bus_valid));

    // R6: the history holds still while frozen
    p_frozen_hold_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_frozen |=> (!$stable(hist_idx) || $stable(hist_pc)));

    // R6: a zero write to the status offset keeps the freeze
    p_zero_write_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_frozen && wr_en && wr_addr == AW'(5) && !wr_data[0]) |=> fifo_frozen);

    // R8: no recording while trace is off
    p_trace_off_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !trace_on |=> (!$stable(hist_idx) || $stable(hist_pc)));
endmodule

bind dbg_bkpt_unit dbg_bkpt_chk #(.IW(HIST_IW), .AW(REG_AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .bus_valid   (bus_valid),
    .hist_idx    (hist_idx),
    .bkpt_req    (bkpt_req),
    .fifo_frozen (fifo_frozen),
    .hist_pc     (hist_pc),
    .trace_on    (trace_on)
);

// File: tb/dbg_bkpt_unit_bench.sv
module dbg_bkpt_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {addr, rd, wr, fetch, expected request}
    localparam logic [35:0] VEC [NVEC] = '{
        {32'h1000_0004, 4'b1001},
        {32'h1000_0FFC, 4'b0101},
        {32'h1000_1000, 4'b1000},
        {32'h1000_0010, 4'b0011},
        {32'h2000_1234, 4'b0010},
        {32'h3000_0000, 4'b0011},
        {32'h2000_0000, 4'b1000},
        {32'h0FFF_FFFC, 4'b0100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_fetch = 1'b0;
    logic [2:0]  hist_idx = '0;
    logic        bkpt_req;
    logic        fifo_frozen;
    logic [31:0] hist_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_bkpt_unit u_dbg_bkpt_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_fetch(bus_fetch), .hist_idx(hist_idx), .bkpt_req(bkpt_req),
        .fifo_frozen(fifo_frozen), .hist_pc(hist_pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic r, input logic w, input logic f);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_rd = r; bus_wr = w; bus_fetch = f;
        @(negedge clk);
        bus_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_fetch = 1'b0;
    endtask

    task automatic read_hist(input logic [2:0] i, output logic [31:0] v);
        hist_idx = i;
        #1;
        v = hist_pc;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 reset req", {31'b0, bkpt_req}, 32'd0);
        check("R9 reset frozen", {31'b0, fifo_frozen}, 32'd0);
        read_hist(3'd0, v); check("R9 reset history", v, 32'd0);

        // R10 register map: A in-window rd/wr, B outside-window fetch, trace on
        reg_wr(3'd0, 32'h1000_0000);
        reg_wr(3'd1, 32'hFFFF_F000);
        reg_wr(3'd2, 32'h2000_0000);
        reg_wr(3'd3, 32'hFFFF_0000);
        reg_wr(3'd4, 32'h0000_2A47);

        // R1 R2 R3 R4 vector table
        for (int k = 0; k < NVEC; k++) begin
            access(VEC[k][35:4], VEC[k][3], VEC[k][2], VEC[k][1]);
            check($sformatf("R1/R2/R3 vector %0d", k), {31'b0, bkpt_req}, {31'b0, VEC[k][0]});
            @(negedge clk);
            check($sformatf("R4 pulse ends vector %0d", k), {31'b0, bkpt_req}, 32'd0);
        end

        // R7 history order
        read_hist(3'd0, v); check("R7 newest", v, 32'h3000_0000);
        read_hist(3'd1, v); check("R7 second", v, 32'h2000_1234);
        read_hist(3'd2, v); check("R7 third", v, 32'h1000_0010);
        read_hist(3'd3, v); check("R7 unused slot", v, 32'd0);

        // R3 channel switched off
        reg_wr(3'd4, 32'h0000_2A46);
        access(32'h1000_0004, 1'b1, 1'b0, 1'b0);
        check("R3 enable low", {31'b0, bkpt_req}, 32'd0);
        // R3 reserved bit4 alone selects nothing
        reg_wr(3'd4, 32'h0000_2A51);
        access(32'h1000_0004, 1'b1, 1'b0, 1'b0);
        check("R3 no kind selected", {31'b0, bkpt_req}, 32'd0);

        // R8 trace off: matching continues, no recording
        reg_wr(3'd4, 32'h0000_0A47);
        access(32'h3000_0004, 1'b0, 1'b0, 1'b1);
        check("R8 match with trace off", {31'b0, bkpt_req}, 32'd1);
        read_hist(3'd0, v); check("R8 no record", v, 32'h3000_0000);

        // R5 freeze select
        reg_wr(3'd4, 32'h0000_3A47);
        access(32'h4000_0000, 1'b0, 1'b0, 1'b1);
        check("R5 B hit no req", {31'b0, bkpt_req}, 32'd0);
        check("R5 frozen set", {31'b0, fifo_frozen}, 32'd1);
        read_hist(3'd0, v); check("R7 trigger fetch kept", v, 32'h4000_0000);
        access(32'h1000_0008, 1'b1, 1'b0, 1'b0);
        check("R5 A still requests", {31'b0, bkpt_req}, 32'd1);
        access(32'h5000_0000, 1'b0, 1'b0, 1'b1);
        read_hist(3'd0, v); check("R6 no update frozen", v, 32'h4000_0000);

        // R6 status clear
        reg_wr(3'd5, 32'd0);
        check("R6 zero write keeps", {31'b0, fifo_frozen}, 32'd1);
        reg_wr(3'd5, 32'd1);
        check("R6 one write clears", {31'b0, fifo_frozen}, 32'd0);
        access(32'h2000_0010, 1'b0, 1'b0, 1'b1);
        read_hist(3'd0, v); check("R6 recording resumes", v, 32'h2000_0010);

        // R7 wrap
        for (int i = 0; i < 9; i++) access(32'h2000_0100 + 32'(4 * i), 1'b0, 1'b0, 1'b1);
        read_hist(3'd0, v); check("R7 wrap newest", v, 32'h2000_0120);
        read_hist(3'd7, v); check("R7 wrap oldest", v, 32'h2000_0104);

        // R9 reset clears controls
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        access(32'h1000_0004, 1'b1, 1'b0, 1'b0);
        check("R9 channel cleared", {31'b0, bkpt_req}, 32'd0);
        access(32'h0000_1234, 1'b0, 1'b0, 1'b1);
        read_hist(3'd0, v); check("R9 trace cleared", v, 32'd0);
        check("R9 frozen cleared", {31'b0, fifo_frozen}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule